// File: doc/BRIEF.md
# Four-Channel Request-Driven DMA Engine

This block moves data between locations in a shared memory on behalf of peripherals. It has four independent channels. Software programs each channel through a small word-indexed register port with a source pointer, a destination pointer, a 24-bit unit count and a packed control word. A single global operation word then arms the whole engine. From that point, pulses on six request lines advance the channels. Each matching request moves exactly one transfer unit. The engine reads the unit and writes it back over a simple word-wide memory master. It then steps both pointers, decrements the count, and reports completion through a per-channel end flag and a level interrupt.

The control word selects several things: the unit size from a fixed table, independent stepping for the source and the destination pointer, and a 4-bit code that names the request line the channel answers to. Units of 8 or 32 bytes are moved as consecutive 32-bit beats. Requests that arrive while a unit is in flight are held, one per channel. When several channels are waiting, the lowest-numbered channel goes first.

Top module: `dma4_top`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and neither `memRd` nor `memWr` is asserted.
- R2: The engine starts units only while the low three bits of the operation word (register index 16) equal 3'b001; the upper bits are ignored; any other value leaves all channels untouched.
- R3: A channel answers requests only when its control bit 0 (enable) is 1 and control bit 1 (end flag) is 0.
- R4: Control bits [11:8] pick the request: code 0 answers `reqIn[0]`. Codes 8, 9, 10 and 11 answer `reqIn[1]`, `reqIn[2]`, `reqIn[3]` and `reqIn[4]`. Every code from 12 to 15 answers `reqIn[5]`. Codes 1 to 7 answer no request line.
- R5: Control bits [6:4] give the unit size in bytes: 0 gives 8, 1 gives 1, 2 gives 2, 3 gives 4, 4 gives 32, and 5 to 7 give 1. A unit is max(1, size/4) beats. Beat k reads the word at source+4k, and the next cycle writes that word to destination+4k.
- R6: After a unit, each pointer is stepped by its own field, the destination by bits [15:14] and the source by bits [13:12]. A field value of 1 adds the unit size, 2 subtracts it, and 0 or 3 leaves the pointer unchanged.
- R7: The count register keeps only its low 24 bits and drops by one per unit. A programmed 0 stands for 2^24 units, so one unit leaves 0xFFFFFF.
- R8: When a unit brings the count to zero, control bit 1 is set. `irq[c]` rises if control bit 2 (interrupt enable) is 1.
- R9: A software control write that leaves bits 2 and 1 not both set drops `irq[c]`. A write that keeps both set leaves it high.
- R10: Of several waiting channels the lowest index is served first. One request arriving while its channel's unit is still in flight is held and served afterwards.
- R11: Channel c occupies register indices 4c to 4c+3 (byte spacing 0x10), holding source, destination, count and control in that order. Reads return the live values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 5 | Word index: bit 4 selects the operation word, [3:2] channel, [1:0] register |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regIdx` (combinational) |
| reqIn | input | 6 | Request pulses: external, serial tx-empty, serial rx-full, FIFO serial tx-empty, FIFO serial rx-full, timer |
| memRd | output | 1 | Read beat; `memRdata` is taken at the end of this cycle |
| memWr | output | 1 | Write beat |
| memAddr | output | 32 | Byte address of the current beat |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid in the `memRd` cycle |
| irq | output | 4 | Per-channel end-of-transfer interrupt level |

## Verification
The bench builds the block with its package defaults: four channels, 24-bit counts and 32-bit pointers. With eight-beat 32-byte units, the held-request case and fixed-priority ordering between channels become visible on the memory port. The 24-bit count lets the zero-means-2^24 wrap appear after a single unit. A seeded random loop varies channel, unit size, both step modes, request line and unit count. A small memory model records every write so that addresses and data can be compared beat by beat.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NCH   = 4;
  localparam int CHW   = $clog2(NCH);
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int CNTW  = 24;
  localparam int BEATW = 3;
  localparam int NREQ  = 6;
  localparam int REGIW = CHW + 3;

  typedef struct packed {
    logic            rdPhase;
    logic            wrPhase;
    logic            commit;
    logic [CHW-1:0]  chan;
    logic [BEATW-1:0] beat;
  } dpStrobe_t;

  function automatic logic [5:0] unitBytes(input logic [2:0] sz);
    case (sz)
      3'd0: return 6'd8;
      3'd2: return 6'd2;
      3'd3: return 6'd4;
      3'd4: return 6'd32;
      default: return 6'd1;
    endcase
  endfunction

  function automatic logic [BEATW-1:0] lastBeat(input logic [2:0] sz);
    case (sz)
      3'd0: return BEATW'(1);
      3'd4: return BEATW'(7);
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] a,
                                             input logic [1:0] mode,
                                             input logic [2:0] sz);
    logic [AW-1:0] d;
    d = {{(AW-6){1'b0}}, unitBytes(sz)};
    case (mode)
      2'd1: return a + d;
      2'd2: return a - d;
      default: return a;
    endcase
  endfunction

  function automatic logic reqHit(input logic [3:0] code, input logic [NREQ-1:0] req);
    case (code)
      4'd0:  return req[0];
      4'd8:  return req[1];
      4'd9:  return req[2];
      4'd10: return req[3];
      4'd11: return req[4];
      4'd12, 4'd13, 4'd14, 4'd15: return req[5];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dma4_datapath.sv
module dma4_datapath
  import dma4_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic [REGIW-1:0]           regIdx,
  input  logic [DW-1:0]              regWdata,
  output logic [DW-1:0]              regRdata,
  input  dpStrobe_t                  strb,
  input  logic [DW-1:0]              memRdata,
  output logic [AW-1:0]              memAddr,
  output logic [DW-1:0]              memWdata,
  output logic [NCH-1:0]             chActive,
  output logic [NCH-1:0][3:0]        chCode,
  output logic [NCH-1:0][BEATW-1:0]  chLast,
  output logic                       opOk,
  output logic [NCH-1:0]             irq
);
  logic [NCH-1:0][AW-1:0]   srcR, dstR;
  logic [NCH-1:0][CNTW-1:0] cntR, cntNext;
  logic [NCH-1:0][DW-1:0]   ctlR;
  logic [DW-1:0]            opReg, dataReg;
  logic [NCH-1:0]           irqR;

  logic           isOp;
  logic [CHW-1:0] selCh;
  logic [1:0]     selReg;
  assign isOp   = regIdx[REGIW-1];
  assign selCh  = regIdx[CHW+1:2];
  assign selReg = regIdx[1:0];

  assign opOk = (opReg[2:0] == 3'b001);
  assign irq  = irqR;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign chActive[g] = ctlR[g][0] & ~ctlR[g][1];
    assign chCode[g]   = ctlR[g][11:8];
    assign chLast[g]   = lastBeat(ctlR[g][6:4]);
    assign cntNext[g]  = cntR[g] - {{(CNTW-1){1'b0}}, 1'b1};
  end

  logic [AW-1:0] baseAddr;
  assign baseAddr = strb.wrPhase ? dstR[strb.chan] : srcR[strb.chan];
  assign memAddr  = baseAddr + {{(AW-BEATW-2){1'b0}}, strb.beat, 2'b00};
  assign memWdata = dataReg;

  always_comb begin
    regRdata = '0;
    if (isOp) regRdata = opReg;
    else begin
      case (selReg)
        2'd0: regRdata = srcR[selCh];
        2'd1: regRdata = dstR[selCh];
        2'd2: regRdata = {{(DW-CNTW){1'b0}}, cntR[selCh]};
        default: regRdata = ctlR[selCh];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcR <= '0; dstR <= '0; cntR <= '0; ctlR <= '0;
      opReg <= '0; dataReg <= '0; irqR <= '0;
    end else begin
      if (strb.rdPhase) dataReg <= memRdata;
      if (regWe && isOp) opReg <= regWdata;
      for (int c = 0; c < NCH; c++) begin
        if (regWe && !isOp && selCh == CHW'(c)) begin
          case (selReg)
            2'd0: srcR[c] <= regWdata;
            2'd1: dstR[c] <= regWdata;
            2'd2: cntR[c] <= regWdata[CNTW-1:0];
            default: begin
              ctlR[c] <= regWdata;
              if (!(regWdata[2] && regWdata[1])) irqR[c] <= 1'b0;
            end
          endcase
        end
        // a completing unit takes precedence over a same-cycle software write
        if (strb.commit && strb.chan == CHW'(c)) begin
          srcR[c] <= stepAddr(srcR[c], ctlR[c][13:12], ctlR[c][6:4]);
          dstR[c] <= stepAddr(dstR[c], ctlR[c][15:14], ctlR[c][6:4]);
          cntR[c] <= cntNext[c];
          if (cntNext[c] == '0) begin
            ctlR[c][1] <= 1'b1;
            if (ctlR[c][2]) irqR[c] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma4_control.sv
module dma4_control
  import dma4_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NREQ-1:0]            reqIn,
  input  logic [NCH-1:0]             chActive,
  input  logic [NCH-1:0][3:0]        chCode,
  input  logic [NCH-1:0][BEATW-1:0]  chLast,
  input  logic                       opOk,
  output dpStrobe_t                  strb,
  output logic                       memRd,
  output logic                       memWr
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t state;

  logic [NCH-1:0]   pend, keep, hit, ready, grantMask;
  logic [CHW-1:0]   chanR, grantIdx;
  logic [BEATW-1:0] beatR;
  logic             anyReady, atLast;

  assign keep  = chActive & {NCH{opOk}};
  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = keep[g] & reqHit(chCode[g], reqIn);
  end
  assign ready    = pend & keep;
  assign anyReady = |ready;

  always_comb begin
    grantIdx = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (ready[c]) grantIdx = CHW'(c);
  end
  assign grantMask = (state == S_IDLE && anyReady) ? (NCH'(1) << grantIdx) : '0;
  assign atLast    = (beatR == chLast[chanR]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; pend <= '0; chanR <= '0; beatR <= '0;
    end else begin
      pend <= (pend & keep & ~grantMask) | hit;
      case (state)
        S_IDLE: if (anyReady) begin
          state <= S_RD; chanR <= grantIdx; beatR <= '0;
        end
        S_RD: state <= S_WR;
        default: begin
          if (atLast) state <= S_IDLE;
          else begin
            state <= S_RD; beatR <= beatR + BEATW'(1);
          end
        end
      endcase
    end
  end

  assign strb.rdPhase = (state == S_RD);
  assign strb.wrPhase = (state == S_WR);
  assign strb.commit  = (state == S_WR) && atLast;
  assign strb.chan    = chanR;
  assign strb.beat    = beatR;
  assign memRd = strb.rdPhase;
  assign memWr = strb.wrPhase;
endmodule

// File: rtl/dma4_top.sv
module dma4_top
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REGIW-1:0]  regIdx,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic [NREQ-1:0]   reqIn,
  output logic              memRd,
  output logic              memWr,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  input  logic [DW-1:0]     memRdata,
  output logic [NCH-1:0]    irq
);
  dpStrobe_t                 strb;
  logic [NCH-1:0]            chActive;
  logic [NCH-1:0][3:0]       chCode;
  logic [NCH-1:0][BEATW-1:0] chLast;
  logic                      opOk;

  dma4_control ctrl_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .chActive(chActive), .chCode(chCode),
    .chLast(chLast), .opOk(opOk), .strb(strb), .memRd(memRd), .memWr(memWr)
  );

  dma4_datapath dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .strb(strb), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .chActive(chActive), .chCode(chCode), .chLast(chLast),
    .opOk(opOk), .irq(irq)
  );
endmodule

// File: rtl/dma4_checker.sv
module dma4_checker
  import dma4_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           memRd,
  input logic           memWr,
  input logic           regWe,
  input logic           opOk,
  input logic [NCH-1:0] irq
);
  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rstN) !(memRd && memWr));

  p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (!rstN) memRd |=> memWr);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!opOk && !memRd && !memWr) |=> !memRd);

  for (genvar g = 0; g < NCH; g++) begin : g_irq
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[g]) |-> $past(memWr));
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irq[g]) |-> $past(regWe));
  end
endmodule

bind dma4_top dma4_checker chk_i (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr),
  .regWe(regWe), .opOk(opOk), .irq(irq)
);

// File: tb/dma4_top_tb_top.sv
module dma4_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regIdx = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [5:0]  reqIn = '0;
  logic        memRd, memWr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  irq;

  int errs = 0;
  int checks = 0;
  logic [31:0] mem [256];
  logic [31:0] logA [64];
  logic [31:0] logD [64];
  int logN = 0;

  always #2 clk = ~clk;

  dma4_top dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .reqIn(reqIn), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .irq(irq)
  );

  assign memRdata = mem[memAddr[9:2]];

  always @(negedge clk) begin
    if (memWr) begin
      if (logN < 64) begin
        logA[logN] = memAddr;
        logD[logN] = memWdata;
      end
      logN = logN + 1;
      mem[memAddr[9:2]] = memWdata;
    end
  end

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic int ubytes(input int sz);
    case (sz)
      0: return 8;
      2: return 2;
      3: return 4;
      4: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic int beatsOf(input int sz);
    return (ubytes(sz) > 4) ? ubytes(sz) / 4 : 1;
  endfunction

  function automatic logic [31:0] nextA(input logic [31:0] a, input int mode, input int sz);
    if (mode == 1) return a + 32'(ubytes(sz));
    if (mode == 2) return a - 32'(ubytes(sz));
    return a;
  endfunction

  function automatic logic [31:0] mkCtl(input int dm, input int sm, input int code,
                                        input int sz, input int ie, input int te, input int en);
    return {16'h0, 2'(dm), 2'(sm), 4'(code), 1'b0, 3'(sz), 1'b0, 1'(ie), 1'(te), 1'(en)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regIdx = 5'(idx); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    regIdx = 5'(idx);
    #1 d = regRdata;
  endtask

  task automatic pulse(input int t);
    @(negedge clk);
    reqIn[t] = 1'b1;
    @(negedge clk);
    reqIn = '0;
    repeat (24) @(negedge clk);
  endtask

  task automatic clearAll();
    for (int c = 0; c < 4; c++) wr(c * 4 + 3, 32'h0);
  endtask

  task automatic setupCh(input int c, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] n, input logic [31:0] ctl);
    wr(c * 4 + 0, s);
    wr(c * 4 + 1, d);
    wr(c * 4 + 2, n);
    wr(c * 4 + 3, ctl);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int r = 0; r <= 16; r++) begin
      rd(r, v);
      check("R1 register after reset", v, 32'h0);
    end
    check("R1 irq after reset", {28'h0, irq}, 32'h0);
    check("R1 memory port idle", {30'h0, memRd, memWr}, 32'h0);

    // R2 global gate
    setupCh(0, 32'h100, 32'h300, 32'd3, mkCtl(1, 1, 0, 3, 0, 0, 1));
    pulse(0); rd(2, v); check("R2 op=0 blocks", v, 32'd3);
    wr(16, 32'h3); pulse(0); rd(2, v); check("R2 op=3 blocks", v, 32'd3);
    wr(16, 32'h5); pulse(0); rd(2, v); check("R2 op=5 blocks", v, 32'd3);
    logN = 0;
    wr(16, 32'hF1); pulse(0); rd(2, v); check("R2 op=0xF1 runs", v, 32'd2);
    check("R5 one beat for 4-byte unit", 32'(logN), 32'd1);
    check("R5 write address", logA[0], 32'h300);
    check("R5 write data", logD[0], pat(32'h40));
    rd(0, v); check("R6 source incremented", v, 32'h104);
    rd(1, v); check("R6 destination incremented", v, 32'h304);

    // R4 request matching
    clearAll(); wr(16, 32'h1);
    setupCh(0, 32'h100, 32'h300, 32'd3, mkCtl(1, 1, 9, 3, 0, 0, 1));
    pulse(0); pulse(1); pulse(3); pulse(4); pulse(5);
    rd(2, v); check("R4 code 9 ignores other lines", v, 32'd3);
    pulse(2); rd(2, v); check("R4 code 9 answers reqIn[2]", v, 32'd2);
    wr(3, mkCtl(1, 1, 5, 3, 0, 0, 1));
    for (int t = 0; t < 6; t++) pulse(t);
    rd(2, v); check("R4 code 5 answers nothing", v, 32'd2);

    // R3 inactive channel
    wr(3, mkCtl(1, 1, 0, 3, 0, 1, 1));
    pulse(0); rd(2, v); check("R3 end flag set blocks", v, 32'd2);
    wr(3, mkCtl(1, 1, 0, 3, 0, 0, 0));
    pulse(0); rd(2, v); check("R3 enable clear blocks", v, 32'd2);

    // R8 / R9 end of transfer and interrupt
    clearAll();
    setupCh(2, 32'h100, 32'h300, 32'd1, mkCtl(1, 1, 0, 3, 1, 0, 1));
    pulse(0);
    rd(10, v); check("R8 count reaches zero", v, 32'd0);
    rd(11, v); check("R8 end flag set", v & 32'h2, 32'h2);
    check("R8 irq raised", {28'h0, irq}, 32'h4);
    logN = 0; pulse(0);
    check("R3 ended channel ignores request", 32'(logN), 32'd0);
    wr(11, mkCtl(1, 1, 0, 3, 1, 1, 1));
    check("R9 keeping both bits holds irq", {28'h0, irq}, 32'h4);
    wr(11, mkCtl(1, 1, 0, 3, 0, 1, 1));
    check("R9 clearing enable drops irq", {28'h0, irq}, 32'h0);
    setupCh(2, 32'h100, 32'h300, 32'd1, mkCtl(1, 1, 0, 3, 1, 0, 1));
    pulse(0);
    check("R8 irq raised again", {28'h0, irq}, 32'h4);
    wr(11, mkCtl(1, 1, 0, 3, 1, 0, 1));
    check("R9 clearing end flag drops irq", {28'h0, irq}, 32'h0);
    setupCh(2, 32'h100, 32'h300, 32'd1, mkCtl(1, 1, 0, 3, 0, 0, 1));
    pulse(0);
    rd(11, v); check("R8 end flag without interrupt", v & 32'h2, 32'h2);
    check("R8 no irq when disabled", {28'h0, irq}, 32'h0);

    // R7 zero count means 2^24
    clearAll();
    setupCh(1, 32'h100, 32'h300, 32'd0, mkCtl(0, 0, 0, 1, 1, 0, 1));
    pulse(0);
    rd(6, v); check("R7 zero count wraps", v, 32'h00FFFFFF);
    rd(7, v); check("R7 no end flag after wrap", v & 32'h2, 32'h0);
    wr(6, 32'hFFABCDEF); rd(6, v); check("R7 count keeps 24 bits", v, 32'h00ABCDEF);

    // R10 priority and held request
    clearAll();
    setupCh(2, 32'h100, 32'h340, 32'd5, mkCtl(1, 1, 0, 3, 0, 0, 1));
    setupCh(1, 32'h100, 32'h300, 32'd5, mkCtl(1, 1, 0, 3, 0, 0, 1));
    logN = 0; pulse(0);
    check("R10 two units", 32'(logN), 32'd2);
    check("R10 channel 1 first", logA[0], 32'h300);
    check("R10 channel 2 second", logA[1], 32'h340);
    clearAll();
    setupCh(0, 32'h100, 32'h300, 32'd5, mkCtl(1, 1, 0, 4, 0, 0, 1));
    logN = 0;
    @(negedge clk); reqIn[0] = 1'b1;
    @(negedge clk); reqIn = '0;
    repeat (4) @(negedge clk);
    reqIn[0] = 1'b1;
    @(negedge clk); reqIn = '0;
    repeat (50) @(negedge clk);
    rd(2, v); check("R10 held request served", v, 32'd3);
    check("R5 sixteen beats for two 32-byte units", 32'(logN), 32'd16);
    check("R5 second beat address", logA[1], 32'h304);

    // R11 register layout
    wr(12, 32'hDEAD0010); rd(12, v); check("R11 channel 3 source", v, 32'hDEAD0010);
    wr(13, 32'hBEEF0020); rd(13, v); check("R11 channel 3 destination", v, 32'hBEEF0020);
    rd(16, v); check("R11 operation word", v, 32'h1);

    // random mix: R4 R5 R6 R7 R8
    for (int it = 0; it < 40; it++) begin
      int c, sz, sm, dm, t, ie, n, k, code, bt, li;
      logic [31:0] s0, d0, sA, dA;
      c = $urandom % 4; sz = $urandom % 8; sm = $urandom % 4; dm = $urandom % 4;
      t = $urandom % 6; ie = $urandom % 2;
      n = $urandom_range(1, 4); k = $urandom_range(1, n);
      code = (t == 0) ? 0 : (t == 5) ? 12 + ($urandom % 4) : 7 + t;
      s0 = 32'h100 + 32'(4 * ($urandom % 8));
      d0 = 32'h300 + 32'(4 * ($urandom % 8));
      clearAll();
      setupCh(c, s0, d0, 32'(n), mkCtl(dm, sm, code, sz, ie, 0, 1));
      logN = 0;
      for (int p = 0; p < k; p++) pulse(t);
      bt = beatsOf(sz);
      check("R5 random beat count", 32'(logN), 32'(k * bt));
      sA = s0; dA = d0; li = 0;
      for (int u = 0; u < k; u++) begin
        for (int b = 0; b < bt; b++) begin
          if (li < 64) begin
            check("R5 random write address", logA[li], dA + 32'(4 * b));
            check("R5 random write data", logD[li], pat(int'((sA + 32'(4 * b)) >> 2) & 255));
          end
          li++;
        end
        sA = nextA(sA, sm, sz);
        dA = nextA(dA, dm, sz);
      end
      rd(c * 4 + 0, v); check("R6 random source", v, sA);
      rd(c * 4 + 1, v); check("R6 random destination", v, dA);
      rd(c * 4 + 2, v); check("R7 random count", v, 32'(n - k));
      rd(c * 4 + 3, v); check("R8 random end flag", v & 32'h2, (k == n) ? 32'h2 : 32'h0);
      check("R8 random irq", {28'h0, irq}, (k == n && ie == 1) ? (32'h1 << c) : 32'h0);
    end

    finishRun();
  end
endmodule